// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is a behavioural responder that behaves like a small single-lane serial NOR flash. A host drives chip select, the serial clock and serial data in; the block answers on serial data out. The storage is a scaled-down byte array held in flip-flops, split into pages for programming and into sectors for erasing. The supported commands are a plain read, a write-enable, a status read, a page program, a sector erase and a whole-array erase.

All serial pins are sampled by a faster system clock and passed through two-stage synchronizers, so the serial clock is treated as data and the whole block runs in a single clock domain. Programming data is collected in a page buffer and applied to the array in one cycle when chip select rises. Erases are applied at the same point. After a program or erase, a write-in-progress flag stays high for a fixed number of system clock cycles.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, so is low, every array byte reads 0xFF, and the status byte is 0x00.
- R2: Read (opcode 0x03) takes three address bytes, most significant bit first, sampled on serial clock rising edges. The most significant bit of the first data byte appears on the falling edge right after the last address bit, with no dummy cycles. Every byte is shifted out most significant bit first.
- R3: A read returns bytes from increasing addresses until chip select rises, and it continues at address 0 after the highest address.
- R4: Address bits above the array width are ignored, so an address selects byte (address modulo ARRAY_BYTES).
- R5: Opcode 0x06 sets the write-enable latch when chip select rises. Opcode 0x05 returns the status byte (bit 0 = write in progress, bit 1 = write-enable latch, other bits 0) repeatedly while chip select stays low.
- R6: Page program (opcode 0x02, three address bytes, then 1 to PAGE_BYTES data bytes) changes each addressed byte to the old value AND the new value when chip select rises, and it clears the write-enable latch.
- R7: Program data that runs past the end of a page wraps to offset 0 of the same page. When one location receives more than one byte, the last byte received for it is used.
- R8: Sector erase (opcode 0xD8 plus three address bytes) sets every byte of the addressed SECTOR_BYTES-aligned sector to 0xFF and leaves the other sectors unchanged.
- R9: Bulk erase (opcode 0x60, no address) sets every array byte to 0xFF.
- R10: A program or erase sent while the write-enable latch is clear leaves the array unchanged.
- R11: Write in progress is high for BUSY_CYCLES clock cycles after a program or erase is applied. A write-enable, program or erase that completes while it is high is ignored.
- R12: These commands are ignored and leave the write-enable latch as it was: a command cut off by chip select before its address is complete, a program with no complete data byte, and an unknown opcode. Trailing bits that do not make up a whole byte are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low; a rising edge ends a command |
| sck | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data in, sampled on serial clock rising edges |
| so | output | 1 | Serial data out, updated on serial clock falling edges |

## Verification
The assertions assume that the serial clock is slow relative to the system clock, with each half period lasting at least four system clocks. They also assume that chip select changes only while the serial clock is low, and that a new transfer starts only after the synchronizers have settled. Under these assumptions a received byte and the following serial clock fall never arrive in the same cycle. The stimulus meets the assumptions by changing every pin on the falling edge of the system clock, holding each serial clock phase for four system clocks, and adding idle gaps around chip select edges. Expected array contents come from a bench-side copy of the array, which is updated with the AND, wrap and erase rules.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;
  localparam logic [7:0] OPC_READ   = 8'h03;
  localparam logic [7:0] OPC_PROG   = 8'h02;
  localparam logic [7:0] OPC_SERASE = 8'hD8;
  localparam logic [7:0] OPC_BERASE = 8'h60;
  localparam logic [7:0] OPC_WREN   = 8'h06;
  localparam logic [7:0] OPC_STATUS = 8'h05;

  typedef enum logic [2:0] {
    PH_OPCODE, PH_ADDR, PH_RDATA, PH_PDATA, PH_STATUS, PH_HOLD
  } phase_t;

  typedef enum logic [2:0] {
    CK_NONE, CK_READ, CK_PROG, CK_SERASE, CK_BERASE, CK_WREN
  } cmd_kind_t;
endpackage

// File: rtl/fe_spi_link.sv
module fe_spi_link (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n_i,
  input  logic       sck_i,
  input  logic       si_i,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  output logic       sel,
  output logic       cs_rise,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       so
);
  logic [1:0] cs_s, sck_s, si_s;
  logic       sck_prev, cs_prev;
  logic       sck_rise, sck_fall;
  logic [2:0] bit_q, bit_d;
  logic [7:0] rx_q, rx_d, tx_q, tx_d;
  logic       rxv_q, rxv_d, so_q, so_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s     <= 2'b11;
      sck_s    <= 2'b00;
      si_s     <= 2'b00;
      sck_prev <= 1'b0;
      cs_prev  <= 1'b1;
    end else begin
      cs_s     <= {cs_s[0], cs_n_i};
      sck_s    <= {sck_s[0], sck_i};
      si_s     <= {si_s[0], si_i};
      sck_prev <= sck_s[1];
      cs_prev  <= cs_s[1];
    end
  end

  assign sel      = ~cs_s[1];
  assign cs_rise  = cs_s[1] & ~cs_prev;
  assign sck_rise = sel & sck_s[1] & ~sck_prev;
  assign sck_fall = sel & ~sck_s[1] & sck_prev;

  always_comb begin
    bit_d = bit_q;
    rx_d  = rx_q;
    rxv_d = 1'b0;
    tx_d  = tx_q;
    so_d  = so_q;
    if (!sel) begin
      bit_d = 3'd0;
      tx_d  = 8'h00;
      so_d  = 1'b0;
    end else begin
      if (sck_rise) begin
        rx_d  = {rx_q[6:0], si_s[1]};
        bit_d = bit_q + 3'd1;
        rxv_d = (bit_q == 3'd7);
      end
      if (tx_load) begin
        tx_d = tx_byte;
      end else if (sck_fall) begin
        so_d = tx_q[7];
        tx_d = {tx_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 3'd0;
      rx_q  <= 8'h00;
      rxv_q <= 1'b0;
      tx_q  <= 8'h00;
      so_q  <= 1'b0;
    end else begin
      bit_q <= bit_d;
      rx_q  <= rx_d;
      rxv_q <= rxv_d;
      tx_q  <= tx_d;
      so_q  <= so_d;
    end
  end

  assign rx_valid = rxv_q;
  assign rx_byte  = rx_q;
  assign so       = so_q;

  // R2
  rx_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(sel));
  // R2
  load_vs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> !sck_fall);
endmodule

// File: rtl/fe_cmd_ctrl.sv
module fe_cmd_ctrl
  import flash_eng_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int OFF_W       = 5,
  parameter int SOFF_W      = 7,
  parameter int BUSY_CYCLES = 300
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                cs_rise,
  input  logic                rx_valid,
  input  logic [7:0]          rx_byte,
  input  logic [7:0]          rd_data,
  output logic [ADDR_W-1:0]   rd_addr,
  output logic                tx_load,
  output logic [7:0]          tx_byte,
  output logic                buf_clear,
  output logic                buf_wr,
  output logic [OFF_W-1:0]    buf_idx,
  output logic [ADDR_W-OFF_W-1:0]  prog_page,
  output logic [ADDR_W-SOFF_W-1:0] serase_sec,
  output logic                prog_go,
  output logic                serase_go,
  output logic                berase_go
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam logic [BW-1:0] BUSY_INIT = BW'(BUSY_CYCLES);

  phase_t          ph_q, ph_d;
  cmd_kind_t       kind_q, kind_d;
  logic [ADDR_W-1:0] adr_q, adr_d, adr_full, ptr_q, ptr_d;
  logic [1:0]      acnt_q, acnt_d;
  logic [OFF_W-1:0] pidx_q, pidx_d;
  logic            armed_q, armed_d, wel_q, wel_d;
  logic [BW-1:0]   busy_q, busy_d;
  logic            wip, any_go;

  assign wip        = (busy_q != '0);
  assign any_go     = prog_go | serase_go | berase_go;
  assign prog_page  = adr_q[ADDR_W-1:OFF_W];
  assign serase_sec = adr_q[ADDR_W-1:SOFF_W];
  assign buf_idx    = pidx_q;
  assign adr_full   = ADDR_W'({adr_q, rx_byte});

  always_comb begin
    ph_d      = ph_q;
    kind_d    = kind_q;
    adr_d     = adr_q;
    acnt_d    = acnt_q;
    ptr_d     = ptr_q;
    pidx_d    = pidx_q;
    armed_d   = armed_q;
    wel_d     = wel_q;
    busy_d    = wip ? busy_q - BW'(1) : busy_q;
    rd_addr   = ptr_q;
    tx_load   = 1'b0;
    tx_byte   = {6'b0, wel_q, wip};
    buf_clear = 1'b0;
    buf_wr    = 1'b0;
    prog_go   = 1'b0;
    serase_go = 1'b0;
    berase_go = 1'b0;
    if (cs_rise) begin
      ph_d    = PH_OPCODE;
      armed_d = 1'b0;
      if (armed_q && !wip) begin
        case (kind_q)
          CK_WREN:   wel_d = 1'b1;
          CK_PROG:   if (wel_q) begin prog_go   = 1'b1; wel_d = 1'b0; busy_d = BUSY_INIT; end
          CK_SERASE: if (wel_q) begin serase_go = 1'b1; wel_d = 1'b0; busy_d = BUSY_INIT; end
          CK_BERASE: if (wel_q) begin berase_go = 1'b1; wel_d = 1'b0; busy_d = BUSY_INIT; end
          default: ;
        endcase
      end
    end else if (!sel) begin
      ph_d    = PH_OPCODE;
      armed_d = 1'b0;
    end else if (rx_valid) begin
      case (ph_q)
        PH_OPCODE: begin
          acnt_d = 2'd0;
          case (rx_byte)
            OPC_READ:   begin kind_d = CK_READ;   ph_d = PH_ADDR; end
            OPC_PROG:   begin kind_d = CK_PROG;   ph_d = PH_ADDR; end
            OPC_SERASE: begin kind_d = CK_SERASE; ph_d = PH_ADDR; end
            OPC_BERASE: begin kind_d = CK_BERASE; ph_d = PH_HOLD; armed_d = 1'b1; end
            OPC_WREN:   begin kind_d = CK_WREN;   ph_d = PH_HOLD; armed_d = 1'b1; end
            OPC_STATUS: begin kind_d = CK_NONE;   ph_d = PH_STATUS; tx_load = 1'b1; end
            default:    begin kind_d = CK_NONE;   ph_d = PH_HOLD; end
          endcase
        end
        PH_ADDR: begin
          adr_d  = adr_full;
          acnt_d = acnt_q + 2'd1;
          if (acnt_q == 2'd2) begin
            case (kind_q)
              CK_READ: begin
                rd_addr = adr_full;
                tx_byte = rd_data;
                tx_load = 1'b1;
                ptr_d   = adr_full + ADDR_W'(1);
                ph_d    = PH_RDATA;
              end
              CK_PROG: begin
                buf_clear = 1'b1;
                pidx_d    = adr_full[OFF_W-1:0];
                ph_d      = PH_PDATA;
              end
              default: begin
                armed_d = 1'b1;
                ph_d    = PH_HOLD;
              end
            endcase
          end
        end
        PH_RDATA: begin
          tx_byte = rd_data;
          tx_load = 1'b1;
          ptr_d   = ptr_q + ADDR_W'(1);
        end
        PH_PDATA: begin
          buf_wr  = 1'b1;
          pidx_d  = pidx_q + OFF_W'(1);
          armed_d = 1'b1;
        end
        PH_STATUS: tx_load = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_OPCODE;
      kind_q  <= CK_NONE;
      adr_q   <= '0;
      acnt_q  <= 2'd0;
      ptr_q   <= '0;
      pidx_q  <= '0;
      armed_q <= 1'b0;
      wel_q   <= 1'b0;
      busy_q  <= '0;
    end else begin
      ph_q    <= ph_d;
      kind_q  <= kind_d;
      adr_q   <= adr_d;
      acnt_q  <= acnt_d;
      ptr_q   <= ptr_d;
      pidx_q  <= pidx_d;
      armed_q <= armed_d;
      wel_q   <= wel_d;
      busy_q  <= busy_d;
    end
  end

  // R6
  wel_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_go |=> !wel_q);
  // R11
  wip_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_go |=> wip);
  // R11
  busy_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wip |=> (busy_q == $past(busy_q) - BW'(1)));
endmodule

// File: rtl/fe_flash_store.sv
module fe_flash_store #(
  parameter int ARRAY_BYTES  = 512,
  parameter int PAGE_BYTES   = 32,
  parameter int SECTOR_BYTES = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [$clog2(ARRAY_BYTES)-1:0] rd_addr,
  output logic [7:0]          rd_data,
  input  logic                buf_clear,
  input  logic                buf_wr,
  input  logic [$clog2(PAGE_BYTES)-1:0] buf_idx,
  input  logic [7:0]          buf_data,
  input  logic [$clog2(ARRAY_BYTES)-$clog2(PAGE_BYTES)-1:0]   prog_page,
  input  logic [$clog2(ARRAY_BYTES)-$clog2(SECTOR_BYTES)-1:0] serase_sec,
  input  logic                prog_go,
  input  logic                serase_go,
  input  logic                berase_go
);
  localparam int ADDR_W  = $clog2(ARRAY_BYTES);
  localparam int OFF_W   = $clog2(PAGE_BYTES);
  localparam int PG_W    = ADDR_W - OFF_W;
  localparam int SEC_W   = ADDR_W - $clog2(SECTOR_BYTES);

  logic [ARRAY_BYTES*8-1:0] mem_flat;
  logic [PAGE_BYTES*8-1:0]  buf_flat;

  assign rd_data = mem_flat[{rd_addr, 3'b000} +: 8];

  for (genvar j = 0; j < PAGE_BYTES; j++) begin : g_pbuf
    logic [7:0] slot_q, slot_d;
    logic       slot_en;
    always_comb begin
      slot_en = buf_clear | (buf_wr && (buf_idx == OFF_W'(j)));
      slot_d  = buf_clear ? 8'hFF : buf_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= 8'hFF;
      else if (slot_en) slot_q <= slot_d;
    end
    assign buf_flat[j*8 +: 8] = slot_q;
  end

  for (genvar i = 0; i < ARRAY_BYTES; i++) begin : g_cell
    localparam int PG  = i / PAGE_BYTES;
    localparam int SC  = i / SECTOR_BYTES;
    localparam int OFS = i % PAGE_BYTES;
    logic [7:0] cell_q, cell_d;
    logic       cell_en;
    always_comb begin
      cell_en = berase_go
              | (serase_go && (serase_sec == SEC_W'(SC)))
              | (prog_go   && (prog_page  == PG_W'(PG)));
      cell_d  = prog_go ? (cell_q & buf_flat[OFS*8 +: 8]) : 8'hFF;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= 8'hFF;
      else if (cell_en) cell_q <= cell_d;
    end
    assign mem_flat[i*8 +: 8] = cell_q;
  end

  // R6
  only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(serase_go || berase_go) |=> ((mem_flat[7:0] & ~$past(mem_flat[7:0])) == 8'h00));
  // R9
  bulk_top_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    berase_go |=> (mem_flat[ARRAY_BYTES*8-1 -: 8] == 8'hFF));
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine #(
  parameter int ARRAY_BYTES  = 512,
  parameter int PAGE_BYTES   = 32,
  parameter int SECTOR_BYTES = 128,
  parameter int BUSY_CYCLES  = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so
);
  localparam int ADDR_W = $clog2(ARRAY_BYTES);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int SOFF_W = $clog2(SECTOR_BYTES);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              sel, cs_rise, rx_valid, tx_load;
  logic [7:0]        rx_byte, tx_byte, rd_data;
  logic [ADDR_W-1:0] rd_addr;
  logic              buf_clear, buf_wr, prog_go, serase_go, berase_go;
  logic [OFF_W-1:0]  buf_idx;
  logic [ADDR_W-OFF_W-1:0]  prog_page;
  logic [ADDR_W-SOFF_W-1:0] serase_sec;

  fe_spi_link u_link (
    .clk(clk), .rst_n(rst_int_n), .cs_n_i(cs_n), .sck_i(sck), .si_i(si),
    .tx_load(tx_load), .tx_byte(tx_byte), .sel(sel), .cs_rise(cs_rise),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .so(so)
  );

  fe_cmd_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SOFF_W(SOFF_W), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .sel(sel), .cs_rise(cs_rise),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rd_data(rd_data),
    .rd_addr(rd_addr), .tx_load(tx_load), .tx_byte(tx_byte),
    .buf_clear(buf_clear), .buf_wr(buf_wr), .buf_idx(buf_idx),
    .prog_page(prog_page), .serase_sec(serase_sec),
    .prog_go(prog_go), .serase_go(serase_go), .berase_go(berase_go)
  );

  fe_flash_store #(
    .ARRAY_BYTES(ARRAY_BYTES), .PAGE_BYTES(PAGE_BYTES), .SECTOR_BYTES(SECTOR_BYTES)
  ) u_store (
    .clk(clk), .rst_n(rst_int_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .buf_clear(buf_clear), .buf_wr(buf_wr), .buf_idx(buf_idx),
    .buf_data(rx_byte), .prog_page(prog_page), .serase_sec(serase_sec),
    .prog_go(prog_go), .serase_go(serase_go), .berase_go(berase_go)
  );
endmodule

// File: tb/sim_flash_cmd_engine.sv
`timescale 1ns/1ps
module sim_flash_cmd_engine;
  localparam int ARRAY  = 512;
  localparam int PAGE   = 32;
  localparam int SECTOR = 128;
  localparam int BUSY   = 300;
  localparam int HALF   = 4;
  localparam int MASK   = ARRAY - 1;

  logic clk, rst_n, cs_n, sck, si, so;
  int   n_cmp, n_bad;
  bit   done;
  logic [7:0] model [ARRAY];

  flash_cmd_engine #(.ARRAY_BYTES(ARRAY), .PAGE_BYTES(PAGE),
                     .SECTOR_BYTES(SECTOR), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k, input int s);
    return 8'((k * 53 + s * 29 + 11) ^ (s << 3));
  endfunction

  task automatic sel_on();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sel_off();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'h00;
    for (int b = 7; b > 7 - nb; b--) begin
      si = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = so;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] d;
    xfer(a[23:16], d); xfer(a[15:8], d); xfer(a[7:0], d);
  endtask

  task automatic wren();
    logic [7:0] d;
    sel_on(); xfer(8'h06, d); sel_off();
  endtask

  task automatic status(output logic [7:0] s);
    logic [7:0] d;
    sel_on(); xfer(8'h05, d); xfer(8'h00, s); sel_off();
  endtask

  task automatic wait_idle();
    repeat (BUSY + 20) @(negedge clk);
  endtask

  task automatic read_check(input logic [23:0] a, input int n, input string tag);
    logic [7:0] d;
    sel_on(); xfer(8'h03, d); send_addr(a);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, d);
      check(d, model[(int'(a) + k) & MASK], tag);
    end
    sel_off();
  endtask

  task automatic prog(input logic [23:0] a, input int n, input int seed, input bit eff);
    logic [7:0] bm [PAGE];
    logic [7:0] d, v;
    int base, off;
    base = int'(a) & MASK & ~(PAGE - 1);
    off  = int'(a) & (PAGE - 1);
    for (int j = 0; j < PAGE; j++) bm[j] = 8'hFF;
    sel_on(); xfer(8'h02, d); send_addr(a);
    for (int k = 0; k < n; k++) begin
      v = pat(k, seed);
      bm[(off + k) % PAGE] = v;
      xfer(v, d);
    end
    sel_off();
    if (eff) for (int j = 0; j < PAGE; j++) model[base + j] = model[base + j] & bm[j];
  endtask

  task automatic sec_erase(input logic [23:0] a, input bit eff);
    logic [7:0] d;
    int base;
    sel_on(); xfer(8'hD8, d); send_addr(a); sel_off();
    base = int'(a) & MASK & ~(SECTOR - 1);
    if (eff) for (int j = 0; j < SECTOR; j++) model[base + j] = 8'hFF;
  endtask

  task automatic bulk(input bit eff);
    logic [7:0] d;
    sel_on(); xfer(8'h60, d); sel_off();
    if (eff) for (int j = 0; j < ARRAY; j++) model[j] = 8'hFF;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0;
    for (int j = 0; j < ARRAY; j++) model[j] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    check({7'b0, so}, 8'h00, "R1 so after reset");
    status(s);
    check(s, 8'h00, "R1 R5 status after reset");
    read_check(24'h0001FC, 8, "R1 R2 R3 wrap read erased");

    prog(24'h000005, 3, 1, 1'b0);
    wait_idle();
    read_check(24'h000005, 3, "R10 program without write enable");

    for (int p = 0; p < ARRAY / PAGE; p++) begin
      wren();
      if (p == 0) begin
        status(s);
        check(s, 8'h02, "R5 latch set after write enable");
      end
      prog(24'(p * PAGE + (p * 3) % PAGE), 8, p + 2, 1'b1);
      if (p == 0) begin
        status(s);
        check(s, 8'h01, "R6 R11 busy and latch cleared");
        wren();
        wait_idle();
        status(s);
        check(s, 8'h00, "R11 write enable ignored while busy");
      end else begin
        wait_idle();
      end
    end

    wren(); prog(24'h000004, 12, 40, 1'b1); wait_idle();
    read_check(24'h000000, 20, "R6 AND with old contents");

    wren(); prog(24'h000054, 40, 50, 1'b1); wait_idle();
    read_check(24'h000040, 32, "R7 page wrap last byte wins");

    read_check(24'h7E0000, ARRAY + 8, "R4 R3 R6 full sweep high bits ignored");

    wren(); sec_erase(24'h000150, 1'b1); wait_idle();

    wren();
    sel_on(); xfer(8'hD8, d); xfer(8'h00, d); xfer(8'h00, d); sel_off();
    sel_on(); xfer(8'hAB, d); sel_off();
    sel_on(); xfer(8'h02, d); send_addr(24'h000090); xbits(8'h00, 5, d); sel_off();
    status(s);
    check(s, 8'h02, "R12 cut-off commands keep latch");
    read_check(24'h000090, 4, "R12 partial program byte discarded");
    sec_erase(24'h000010, 1'b1); wait_idle();
    read_check(24'h000000, ARRAY, "R8 sector erase sweep");

    sel_on(); xfer(8'h05, d); xfer(8'h00, s); xfer(8'h00, d); sel_off();
    check(s, 8'h00, "R5 status first byte");
    check(d, 8'h00, "R5 status repeated byte");

    bulk(1'b0); wait_idle();
    read_check(24'h000080, 8, "R10 bulk erase without write enable");

    wren(); bulk(1'b1); wait_idle();
    read_check(24'h000000, ARRAY, "R9 bulk erase sweep");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule